// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate behavioural model of a pipelined synchronous SRAM that works in bursts. Words are 36 bits wide and split into four 9-bit byte lanes. The depth is a parameter, kept small by default. On every rising clock edge the block samples three chip selects, two address strobes, a burst-advance input and the write controls.

The two strobes behave differently. The host strobe always starts a read burst. The controller strobe starts a burst whose direction follows the write controls. Once a burst is open, the advance input either steps through a four-word group or holds the current word.

Read data leaves through a single output register. The data bus is split into an input word, an output word and a drive-enable. The drive-enable stands for the tri-state buffer. It is raised only when read data is pending, the sleep input is low and the output enable is low. The bus follows a fixed synchronous protocol, so there is no back-pressure: a read beat always produces its word, and the host must hold off writes while read data is still leaving. Write data is sampled on the same edge as the address or advance of its beat.

Top module: `sync_burst_sram`

## Requirements
- R1: The device is deselected in three cases: sel1_n is high with ctl_strobe_n low; sel2 is low with either strobe low; or sel3_n is high with either strobe low. A deselect performs no access and closes the burst. Advance or hold inputs that follow a deselect perform no access until a new burst starts.
- R2: With all selects active (sel1_n=0, sel2=1, sel3_n=0) and host_strobe_n low, the address is latched and a read burst begins, even when the write controls request a write.
- R3: With all selects active, host_strobe_n high and ctl_strobe_n low, the address is latched and a burst begins. The burst writes if the write decode selects any lane and reads otherwise.
- R4: An advance (advance_n=0) with both strobes high, or with sel1_n high and ctl_strobe_n high, continues the open burst at the next address. Address bits [1:0] increment modulo 4 and the upper bits stay fixed.
- R5: A hold (advance_n=1 under the same strobe conditions as R4) keeps the current address and repeats the access there: a read, or a write per the write decode.
- R6: all_write_n low writes all four lanes, whatever byte_write_n and lane_write_n are.
- R7: With all_write_n high and byte_write_n low, each low bit i of lane_write_n writes lane i, which is bits [9i+8:9i]. Lanes not written keep their old contents. If byte_write_n is high, or all lane bits are high, the beat is a read.
- R8: Read data for an address accessed at edge n appears on dq_out with dq_oe high after edge n+1, for one cycle.
- R9: dq_oe is low whenever sleep is high, whenever out_en_n is high, and during cycles with no pending read data.
- R10: Reset closes any burst, drops pending read data and holds dq_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | Primary chip select, active low |
| sel2 | input | 1 | Secondary chip select, active high |
| sel3_n | input | 1 | Secondary chip select, active low |
| host_strobe_n | input | 1 | Host address strobe, starts read bursts |
| ctl_strobe_n | input | 1 | Controller address strobe, starts read or write bursts |
| advance_n | input | 1 | Low: step burst address; high: hold |
| all_write_n | input | 1 | Global write, all lanes, active low |
| byte_write_n | input | 1 | Enables per-lane writes, active low |
| lane_write_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| sleep | input | 1 | Forces the bus to high impedance |
| out_en_n | input | 1 | Output enable, active low |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable (low = high impedance) |

## Verification
Two situations are hard to reach from the ports. One is a hold or advance arriving just after a deselect. The other is a word whose lanes were written by different beats of one burst. Both can only be told apart by a later read of the same word. The vector table first opens a controller-strobe burst. It writes one lane on the start beat and two other lanes on a hold beat, then reads the word back. The expected value is built lane by lane from the earlier full-word write. Deselects driven by each chip select are followed by advance and hold vectors and by a later read of the address a blocked write targeted.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL,
    CMD_START,
    CMD_NEXT,
    CMD_HOLD
  } burst_cmd_e;
endpackage

// File: rtl/ssram_cmd_decode.sv
module ssram_cmd_decode #(
  parameter int LANES = 4
) (
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    host_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    advance_n,
  input  logic                    all_write_n,
  input  logic                    byte_write_n,
  input  logic [LANES-1:0]        lane_write_n,
  output ssram_pkg::burst_cmd_e   cmd,
  output logic                    write_beat,
  output logic [LANES-1:0]        lane_mask
);
  import ssram_pkg::*;

  logic chip_on;
  logic host_go;
  logic ctl_go;

  assign chip_on = !sel1_n && sel2 && !sel3_n;
  assign host_go = !sel1_n && !host_strobe_n;
  assign ctl_go  = !sel1_n && host_strobe_n && !ctl_strobe_n;

  // global write wins; otherwise byte path gated by byte_write_n
  always_comb begin
    if (!all_write_n)        lane_mask = '1;
    else if (!byte_write_n)  lane_mask = ~lane_write_n;
    else                     lane_mask = '0;
  end

  always_comb begin
    if (sel1_n && !ctl_strobe_n)  cmd = CMD_DESEL;
    else if (host_go || ctl_go)   cmd = chip_on ? CMD_START : CMD_DESEL;
    else if (advance_n)           cmd = CMD_HOLD;
    else                          cmd = CMD_NEXT;
  end

  // a host-strobe start never writes
  assign write_beat = (cmd != CMD_DESEL) && !(cmd == CMD_START && host_go)
                      && (|lane_mask);
endmodule

// File: rtl/ssram_burst_addr.sv
module ssram_burst_addr #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ssram_pkg::burst_cmd_e cmd,
  input  logic [ADDR_W-1:0]     ext_addr,
  output logic [ADDR_W-1:0]     cur_addr,
  output logic                  active,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic                  beat_valid
);
  import ssram_pkg::*;

  logic [BURST_W-1:0] nxt_low;
  logic [ADDR_W-1:0]  nxt_addr;

  assign nxt_low = cur_addr[BURST_W-1:0] + BURST_W'(1);

  generate
    if (BURST_W >= ADDR_W) begin : g_full_wrap
      assign nxt_addr = nxt_low[ADDR_W-1:0];
    end else begin : g_group_wrap
      assign nxt_addr = {cur_addr[ADDR_W-1:BURST_W], nxt_low};
    end
  endgenerate

  always_comb begin
    unique case (cmd)
      CMD_START: beat_addr = ext_addr;
      CMD_NEXT:  beat_addr = nxt_addr;
      default:   beat_addr = cur_addr;
    endcase
  end

  assign beat_valid = (cmd == CMD_START) ||
                      (active && (cmd == CMD_NEXT || cmd == CMD_HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
    end else begin
      unique case (cmd)
        CMD_DESEL: active <= 1'b0;
        CMD_START: begin
          active   <= 1'b1;
          cur_addr <= ext_addr;
        end
        CMD_NEXT:  if (active) cur_addr <= nxt_addr;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
  end
endmodule

// File: rtl/ssram_read_pipe.sv
module ssram_read_pipe #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [WORD_W-1:0] arr_data,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid
);
  logic stage_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_valid <= 1'b0;
      out_valid   <= 1'b0;
      arr_addr    <= '0;
      out_word    <= '0;
    end else begin
      stage_valid <= rd_req;
      if (rd_req) arr_addr <= rd_addr;
      out_valid   <= stage_valid;
      if (stage_valid) out_word <= arr_data;
    end
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH   = 64,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              host_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              advance_n,
  input  logic              all_write_n,
  input  logic              byte_write_n,
  input  logic [LANES-1:0]  lane_write_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sleep,
  input  logic              out_en_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  import ssram_pkg::*;

  burst_cmd_e        cmd;
  logic              write_beat;
  logic [LANES-1:0]  lane_mask;
  logic [ADDR_W-1:0] cur_addr;
  logic              burst_active;
  logic [ADDR_W-1:0] beat_addr;
  logic              beat_valid;
  logic [LANES-1:0]  wr_lanes;
  logic              rd_req;
  logic [ADDR_W-1:0] arr_rd_addr;
  logic [WORD_W-1:0] arr_rd_data;
  logic              out_valid;

  ssram_cmd_decode #(.LANES(LANES)) u_dec (
    .sel1_n, .sel2, .sel3_n, .host_strobe_n, .ctl_strobe_n, .advance_n,
    .all_write_n, .byte_write_n, .lane_write_n,
    .cmd, .write_beat, .lane_mask
  );

  ssram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk, .rst_n, .cmd, .ext_addr(addr),
    .cur_addr, .active(burst_active), .beat_addr, .beat_valid
  );

  assign wr_lanes = (beat_valid && write_beat) ? lane_mask : '0;
  assign rd_req   = beat_valid && !write_beat;

  ssram_lane_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES),
                     .LANE_W(LANE_W)) u_mem (
    .clk, .wr_lanes, .wr_addr(beat_addr), .wr_data(dq_in),
    .rd_addr(arr_rd_addr), .rd_data(arr_rd_data)
  );

  ssram_read_pipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rpipe (
    .clk, .rst_n, .rd_req, .rd_addr(beat_addr),
    .arr_addr(arr_rd_addr), .arr_data(arr_rd_data),
    .out_word(dq_out), .out_valid
  );

  assign dq_oe = out_valid && !sleep && !out_en_n;
endmodule

// File: rtl/ssram_checker.sv
module ssram_checker #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2,
  parameter int LANES   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              sel3_n,
  input logic              host_strobe_n,
  input logic              ctl_strobe_n,
  input logic              advance_n,
  input logic              all_write_n,
  input logic              sleep,
  input logic              out_en_n,
  input logic              dq_oe,
  input logic [LANES-1:0]  wr_lanes,
  input logic              rd_req,
  input logic              burst_active,
  input logic [ADDR_W-1:0] cur_addr
);
  logic chip_on, go_on, cont;
  assign chip_on = !sel1_n && sel2 && !sel3_n;
  assign go_on   = !sel1_n && (!host_strobe_n || !ctl_strobe_n);
  assign cont    = ctl_strobe_n && (host_strobe_n || sel1_n);

  assert_desel_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_n && !ctl_strobe_n) || (go_on && !chip_on) |-> wr_lanes == '0);

  assert_desel_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1_n && !ctl_strobe_n) || (go_on && !chip_on) |=> !burst_active);

  assert_host_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && !host_strobe_n) |-> wr_lanes == '0);

  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !advance_n && burst_active) |=>
      (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])) &&
      (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + 1'b1)));

  assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && advance_n && burst_active) |=> $stable(cur_addr));

  assert_global_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_write_n && wr_lanes != '0) |-> (&wr_lanes));

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(rd_req, 2));

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || out_en_n) |-> !dq_oe);

  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dq_oe && !burst_active));
endmodule

bind sync_burst_sram ssram_checker #(
  .ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
  .host_strobe_n(host_strobe_n), .ctl_strobe_n(ctl_strobe_n),
  .advance_n(advance_n), .all_write_n(all_write_n), .sleep(sleep),
  .out_en_n(out_en_n), .dq_oe(dq_oe), .wr_lanes(wr_lanes), .rd_req(rd_req),
  .burst_active(burst_active), .cur_addr(cur_addr)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel1_n, sel2, sel3_n, host_strobe_n, ctl_strobe_n, advance_n;
  logic        all_write_n, byte_write_n, sleep, out_en_n;
  logic [3:0]  lane_write_n;
  logic [5:0]  addr;
  logic [35:0] dq_in, dq_out;
  logic        dq_oe;
  int          n_tests = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  sync_burst_sram u_dut (
    .clk, .rst_n, .sel1_n, .sel2, .sel3_n, .host_strobe_n, .ctl_strobe_n,
    .advance_n, .all_write_n, .byte_write_n, .lane_write_n, .addr, .sleep,
    .out_en_n, .dq_in, .dq_out, .dq_oe
  );

  typedef struct packed {
    logic [2:0]  sel;   // {sel1_n, sel2, sel3_n}
    logic        hs_n;
    logic        cs_n;
    logic        adv_n;
    logic        gw_n;
    logic        bw_n;
    logic [3:0]  ln_n;
    logic [5:0]  a;
    logic        drv;
    logic [35:0] wd;
    logic        oe_n;
    logic        slp;
    logic        ez;    // expect bus released
    logic [35:0] ed;    // expected word otherwise
  } vec_t;

  function automatic vec_t mk(logic [2:0] sel, logic hs_n, logic cs_n,
      logic adv_n, logic gw_n, logic bw_n, logic [3:0] ln_n, logic [5:0] a,
      logic drv, logic [35:0] wd, logic oe_n, logic slp, logic ez,
      logic [35:0] ed);
    return '{sel, hs_n, cs_n, adv_n, gw_n, bw_n, ln_n, a, drv, wd, oe_n,
             slp, ez, ed};
  endfunction

  localparam logic [2:0]  ON = 3'b010, P_OFF = 3'b110;
  localparam logic [35:0] D0 = 36'hA5A5A5A5A, D1 = 36'h123456789,
                          D2 = 36'h2468ACE02, D3 = 36'h13579BDF1,
                          D4 = 36'hFEDCBA987, ONES = 36'hFFFFFFFFF,
                          MIX = 36'h0000167FF;
  localparam int NV = 25;

  localparam vec_t VEC [NV] = '{
    mk(ON,   1,0,1, 0,1,4'hF, 6'h08, 1,D0,   1,0, 1,0),   // R3 R6 ctl start, global write
    mk(ON,   1,1,0, 0,1,4'hF, 6'h3F, 1,D1,   1,0, 1,0),   // R4 step to 09
    mk(ON,   1,1,0, 0,1,4'hF, 6'h3F, 1,D2,   1,0, 1,0),   // R4 0A
    mk(ON,   1,1,0, 0,1,4'hF, 6'h3F, 1,D3,   1,0, 1,0),   // R4 0B
    mk(ON,   1,1,0, 0,1,4'hF, 6'h3F, 1,D4,   1,0, 1,0),   // R4 wrap to 08
    mk(ON,   0,1,1, 0,1,4'hF, 6'h09, 0,0,    0,0, 1,0),   // R2 host start reads despite write
    mk(ON,   1,1,0, 1,1,4'hF, 6'h3F, 0,0,    0,0, 0,D1),  // R8 R2 data of 09
    mk(ON,   1,1,0, 1,1,4'hF, 6'h3F, 0,0,    0,0, 0,D2),  // R4 read 0A
    mk(ON,   1,1,0, 1,1,4'hF, 6'h3F, 0,0,    0,0, 0,D3),  // R4 read 0B, next wraps
    mk(ON,   1,1,1, 1,1,4'hF, 6'h3F, 0,0,    0,0, 0,D4),  // R5 hold on 08; R4 wrap data
    mk(P_OFF,1,0,1, 1,1,4'hF, 6'h00, 0,0,    0,0, 0,D4),  // R1 deselect via sel1_n; R5 repeat
    mk(P_OFF,1,1,0, 1,1,4'hF, 6'h00, 0,0,    0,0, 1,0),   // R1 advance after deselect: nothing
    mk(3'b011,1,0,1,0,1,4'hF, 6'h08, 1,ONES, 1,0, 1,0),   // R1 sel3_n blocks write
    mk(ON,   1,0,1, 1,0,4'hE, 6'h09, 1,ONES, 1,0, 1,0),   // R7 lane 0 only
    mk(ON,   1,1,1, 1,0,4'h3, 6'h3F, 1,0,    1,0, 1,0),   // R5 R7 hold write lanes 3,2
    mk(ON,   0,1,1, 1,1,4'hF, 6'h09, 0,0,    0,0, 1,0),   // R2 read back 09
    mk(ON,   1,0,1, 1,1,4'h0, 6'h0A, 0,0,    0,0, 0,MIX), // R7 merged lanes; R3 bw_n high reads
    mk(3'b000,0,1,1,1,1,4'hF, 6'h00, 0,0,    0,0, 0,D2),  // R1 sel2 deselect; R3 R7 0A intact
    mk(ON,   0,1,1, 1,1,4'hF, 6'h0B, 0,0,    1,0, 1,0),   // R9 host start, oe high
    mk(P_OFF,1,1,1, 1,1,4'hF, 6'h00, 0,0,    1,0, 1,0),   // R9 data pending but out_en_n high
    mk(ON,   0,1,1, 1,1,4'hF, 6'h0B, 0,0,    0,0, 0,D3),  // R5 hold with sel1_n high read 0B
    mk(P_OFF,1,1,1, 1,1,4'hF, 6'h00, 0,0,    0,1, 1,0),   // R9 sleep releases bus
    mk(ON,   0,1,1, 1,1,4'hF, 6'h08, 0,0,    0,0, 0,D3),  // R9 sleep dropped, data back
    mk(P_OFF,1,0,1, 1,1,4'hF, 6'h00, 0,0,    0,0, 0,D4),  // R1 08 kept after blocked write
    mk(P_OFF,1,1,1, 1,1,4'hF, 6'h00, 0,0,    0,0, 1,0)    // R8 one cycle only
  };

  task automatic apply(input vec_t v);
    {sel1_n, sel2, sel3_n} = v.sel;
    host_strobe_n = v.hs_n;  ctl_strobe_n = v.cs_n;  advance_n = v.adv_n;
    all_write_n = v.gw_n;    byte_write_n = v.bw_n;  lane_write_n = v.ln_n;
    addr = v.a;  out_en_n = v.oe_n;  sleep = v.slp;
    dq_in = v.drv ? v.wd : '0;
  endtask

  task automatic check_bus(input logic ez, input logic [35:0] ed,
                           input string tag);
    n_tests++;
    if (ez) begin
      if (dq_oe !== 1'b0) begin
        n_fail++;
        $display("FAIL %s: dq_oe=%b expected 0", tag, dq_oe);
      end
    end else if (dq_oe !== 1'b1 || dq_out !== ed) begin
      n_fail++;
      $display("FAIL %s: dq_oe=%b dq_out=%h expected oe=1 data=%h",
               tag, dq_oe, dq_out, ed);
    end
  endtask

  task automatic beat(input vec_t v, input string tag);
    @(negedge clk);
    apply(v);
    @(posedge clk);
    #1 dq_in = '0;
    #4 check_bus(v.ez, v.ed, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    apply(mk(P_OFF,1,1,1,1,1,4'hF,6'h00,0,0,0,0,1,0));
    repeat (3) @(posedge clk);
    #5 check_bus(1'b1, '0, "R10 reset state");
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i], $sformatf("vector %0d", i));
    end

    // R8: exact latency, single-cycle window
    beat(mk(ON,0,1,1,1,1,4'hF,6'h0A,0,0,0,0,1,0),    "R8 edge n: not yet");
    beat(mk(P_OFF,1,0,1,1,1,4'hF,6'h00,0,0,0,0,0,D2), "R8 edge n+1: data");
    beat(mk(P_OFF,1,0,1,1,1,4'hF,6'h00,0,0,0,0,1,0),  "R8 edge n+2: released");

    // R10: reset in mid-burst drops the pending read and closes the burst
    beat(mk(ON,0,1,1,1,1,4'hF,6'h0B,0,0,0,0,1,0), "R10 read before reset");
    @(negedge clk);
    apply(mk(P_OFF,1,1,1,1,1,4'hF,6'h00,0,0,0,0,1,0));
    rst_n = 1'b0;
    #1 check_bus(1'b1, '0, "R10 pending read dropped");
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    beat(mk(P_OFF,1,1,0,1,1,4'hF,6'h00,0,0,0,0,1,0), "R10 advance after reset");
    beat(mk(P_OFF,1,1,1,1,1,4'hF,6'h00,0,0,0,0,1,0), "R10 burst stays closed");
    beat(mk(P_OFF,1,1,1,1,1,4'hF,6'h00,0,0,0,0,1,0), "R10 bus idle");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule